// File: doc/BRIEF.md
# Dual-register serial-to-parallel latch

This block turns a serial bit stream into a parallel byte. Serial data moves one stage at a time through a shift chain, one stage for each rising edge of a shift strobe. A second strobe copies the whole chain into a separate storage register in one step. Because the two strobes are independent, the parallel outputs keep their value while the next byte is shifted in. The storage register reaches the parallel outputs through an active-low enable. Each output bit comes with an enable bit in place of a true tri-state driver. The last shift stage is also brought out as a cascade output, so that several blocks can be chained.

The serial data, both strobes and the shift-chain clear can arrive from another timing domain. Each passes through a two-flop synchronizer into the system clock domain, and only a 0-to-1 change of a strobe between samples counts as an edge. The output enable is not registered and acts on the outputs in the same cycle.

Top module: `ser2par_latch`

## Requirements
- R1: Each detected rising edge of `shift_stb` makes stage 0 take the synchronized `ser_in`, and each stage i>0 take the old value of stage i-1.
- R2: Each detected rising edge of `load_stb` copies all eight shift stages into the storage register in one step. Storage bit i is shift stage i, and `par_q[i]` shows storage bit i. Serial data sent first therefore ends up on `par_q[7]` after eight shifts.
- R3: Shifts without a load leave `par_q` unchanged.
- R4: While the synchronized `clr_n` is 0, every shift stage is forced to 0, even when a shift edge arrives in the same cycle. The storage register is not affected.
- R5: When `oe_n` is 1, `par_en` is all zeros and `par_q` is all zeros. When `oe_n` is 0, `par_en` is all ones and `par_q` equals the storage register. This takes effect in the same cycle, with no register on the path.
- R6: With no rising strobe edge, the shift chain and the storage register hold their values. A strobe held high for many cycles counts as exactly one edge.
- R7: `cascade_out` always equals shift stage 7, whatever the value of `oe_n`.
- R8: When a shift edge and a load edge are detected in the same cycle, the storage register receives the chain contents from before that shift.
- R9: After reset, the shift chain and the storage register are both 0.
- R10: A change on `ser_in`, `shift_stb`, `load_stb` or `clr_n` made between clock edges takes effect on state at the third following rising clock edge: two synchronizer flops, then the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial data in |
| shift_stb | input | 1 | Shift strobe, acts on its rising edge |
| clr_n | input | 1 | Active-low clear of the shift chain |
| load_stb | input | 1 | Storage-load strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low output enable |
| par_q | output | 8 | Parallel data, 0 when disabled |
| par_en | output | 8 | Per-bit output enable |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
A wrong bit in the shift chain appears on `cascade_out` once it has moved up to stage 7, which takes at most seven more shifts. After a load it also appears on `par_q` at the matching bit position. A wrong value in the storage register shows on `par_q` at once whenever `oe_n` is low. Wrong strobe edge detection gives a byte shifted by one or more positions after the next load, and the latency check catches a synchronizer of the wrong depth to the exact cycle.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic ser;
    logic shift_stb;
    logic load_stb;
    logic clr_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{ser: 1'b0, shift_stb: 1'b0, load_stb: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned N       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  // R6: a held level never yields two edges in a row
  p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         clr_n,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         upd_en;

  assign upd_en = shift_en | ~clr_n;

  always_comb begin
    if (!clr_n)        q_d = '0;
    else if (shift_en) q_d = {q[W-2:0], din};
    else               q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_d;
  end

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && clr_n) |=> (q == {$past(q[W-2:0]), $past(din)}));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n) |=> (q == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && clr_n) |=> $stable(q));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q == $past(d)));
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/ser2par_latch.sv
module ser2par_latch
  import ser2par_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             clr_n,
  input  logic             load_stb,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_en,
  output logic             cascade_out
);
  localparam int unsigned CW = $bits(ctrl_t);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_sync_n} <= 2'b00;
    else        {rst_meta, rst_sync_n} <= {1'b1, rst_meta};
  end

  ctrl_t raw_c, syn_c;
  assign raw_c = '{ser: ser_in, shift_stb: shift_stb, load_stb: load_stb, clr_n: clr_n};

  sync_chain #(.N(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(raw_c), .q(syn_c)
  );

  logic [1:0] rise_v;
  logic       shift_rise, load_rise;
  rise_detect #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_sync_n),
    .lvl({syn_c.shift_stb, syn_c.load_stb}), .rise(rise_v)
  );
  assign shift_rise = rise_v[1];
  assign load_rise  = rise_v[0];

  logic [WIDTH-1:0] shift_q, store_q;

  shift_chain #(.W(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(shift_rise),
    .clr_n(syn_c.clr_n), .din(syn_c.ser), .q(shift_q)
  );

  hold_reg #(.W(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .load_en(load_rise),
    .d(shift_q), .q(store_q)
  );

  assign cascade_out = shift_q[WIDTH-1];
  assign par_en      = {WIDTH{~oe_n}};
  assign par_q       = oe_n ? '0 : store_q;

  p_simul_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_rise && load_rise) |=> (store_q == $past(shift_q)));
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oe_n |-> (par_en == '0 && par_q == '0));
  p_on_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !oe_n |-> (par_en == '1 && par_q == store_q));
endmodule

// File: tb/ser2par_latch_bench.sv
module ser2par_latch_bench;
  logic clk = 1'b0;
  logic rst_n, ser_in, shift_stb, clr_n, load_stb, oe_n;
  logic [7:0] par_q, par_en;
  logic cascade_out;
  int checks = 0, errors = 0;
  logic [7:0] m_sh, m_st;

  always #5 clk = ~clk;

  ser2par_latch u_ser2par_latch (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb), .clr_n(clr_n),
    .load_stb(load_stb), .oe_n(oe_n), .par_q(par_q), .par_en(par_en),
    .cascade_out(cascade_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_shift(input logic b);
    ser_in = b; shift_stb = 1'b1; tick(3);
    shift_stb = 1'b0; tick(3);
    m_sh = {m_sh[6:0], b};
  endtask

  task automatic pulse_load();
    load_stb = 1'b1; tick(3);
    load_stb = 1'b0; tick(3);
    m_st = m_sh;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; shift_stb = 1'b0; clr_n = 1'b1; load_stb = 1'b0; oe_n = 1'b0;
    m_sh = '0; m_st = '0;
    tick(3); rst_n = 1'b1; tick(5);
    chk("R9 par_q after reset", 32'(par_q), 32'h00);
    chk("R9 cascade after reset", 32'(cascade_out), 32'h0);
    chk("R5 par_en enabled", 32'(par_en), 32'hff);

    // sweep every byte value: shift first bit first, then load
    for (int v = 0; v < 256; v++) begin
      for (int k = 7; k >= 0; k--) begin
        pulse_shift(v[k]);
        chk("R7 cascade is stage 7", 32'(cascade_out), 32'(m_sh[7]));
        chk("R3 outputs hold during shift", 32'(par_q), 32'(m_st));
      end
      pulse_load();
      chk("R2 R1 parallel byte", 32'(par_q), 32'(v));
      if (v % 2 == 1) begin
        oe_n = 1'b1; #1;
        chk("R5 disabled data", 32'(par_q), 32'h00);
        chk("R5 disabled enables", 32'(par_en), 32'h00);
        chk("R7 cascade ignores oe_n", 32'(cascade_out), 32'(m_sh[7]));
        tick(1); oe_n = 1'b0; #1;
        chk("R5 re-enabled data", 32'(par_q), 32'(m_st));
        tick(1);
      end
    end

    // clear: chain zero, storage untouched (R4)
    clr_n = 1'b0; tick(3); clr_n = 1'b1; tick(3); m_sh = '0;
    chk("R4 cascade after clear", 32'(cascade_out), 32'h0);
    chk("R4 storage kept over clear", 32'(par_q), 32'hff);
    pulse_load();
    chk("R4 cleared chain loaded", 32'(par_q), 32'h00);

    // clear wins over a shift in the same cycle (R4)
    for (int i = 0; i < 8; i++) pulse_shift(1'b1);
    ser_in = 1'b1; clr_n = 1'b0; shift_stb = 1'b1; tick(3);
    clr_n = 1'b1; shift_stb = 1'b0; tick(3); m_sh = '0;
    pulse_load();
    chk("R4 clear priority over shift", 32'(par_q), 32'h00);

    // held strobe counts once (R6)
    ser_in = 1'b1; shift_stb = 1'b1; tick(20); shift_stb = 1'b0; tick(3);
    m_sh = 8'h01;
    pulse_load();
    chk("R6 held strobe shifts once", 32'(par_q), 32'h01);

    // latency (R10): m_sh becomes 7F, then one more shift sets stage 7
    for (int i = 0; i < 6; i++) pulse_shift(1'b1);
    chk("R10 setup cascade low", 32'(cascade_out), 32'h0);
    ser_in = 1'b1; shift_stb = 1'b1;
    tick(2);
    chk("R10 no change after two edges", 32'(cascade_out), 32'h0);
    tick(1);
    chk("R10 change after third edge", 32'(cascade_out), 32'h1);
    shift_stb = 1'b0; tick(3); m_sh = 8'hff;

    // simultaneous shift and load (R8)
    ser_in = 1'b0; shift_stb = 1'b1; load_stb = 1'b1; tick(3);
    shift_stb = 1'b0; load_stb = 1'b0; tick(3);
    m_st = m_sh; m_sh = {m_sh[6:0], 1'b0};
    chk("R8 load sees pre-shift chain", 32'(par_q), 32'(m_st));
    pulse_load();
    chk("R8 shift still happened", 32'(par_q), 32'hfe);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule